// File: doc/BRIEF.md
# Software-Managed Translation Lookaside Buffer

This block is a small, fully associative translation buffer whose contents software controls completely. Every slot holds a virtual page number, a contiguous low-order page mask, an address-space tag, a global flag and an even/odd pair of physical frame numbers, each frame with its own valid bit. A lookup compares the request against all slots in parallel and returns, in the same cycle, a hit flag, the index of the matching slot and the selected frame number. The same lookup serves as a probe, because the index is reported even when the selected half of the pair is not valid.

Software fills slots through an indexed write port. It can clear the whole table with a flush. It picks replacement victims with a next-slot pointer: the pointer presents the contents of the slot it addresses and steps forward on command. Two stateless checks flag a misaligned instruction fetch address and an address that lies in the uncacheable window. Four counters record lookup outcomes, split by read and write, and the block also gives hit and miss totals.

Top module: `swtlb_top`

## Requirements
- R1: A slot matches a lookup when at least one of its two valid bits is set, when its global flag is set or its stored address-space tag equals the request's tag, and when the request page number equals the stored one on every bit above the slot's select bit. The page-mask bits and the select bit take no part in the comparison.
- R2: The page mask holds k ones at bits 0..k-1, and bit k of the request page number is the select bit. When the select bit is 0, the even frame and its valid bit are used; when it is 1, the odd frame and its valid bit are used. If the used valid bit is clear, `lk_hit` is 0, while `lk_idx` still gives the matching slot.
- R3: When several slots match, the lowest index wins. `lk_idx` is all ones (width log2(ENTRIES)+1) when no slot matches. All lookup outputs are combinational.
- R4: A write with `wr_idx` below ENTRIES replaces that whole slot, and the new contents are seen from the next cycle on.
- R5: A write with `wr_idx` of ENTRIES or more changes no slot, and `wr_oor` is high in the same cycle.
- R6: `flush` clears every slot and returns the next-slot pointer to 0 at the next edge. It takes priority over a write or an advance in the same cycle.
- R7: The `nxt_*` outputs show the slot that `nxt_ptr` addresses. `nxt_adv` steps the pointer by one at the next edge, and the step after ENTRIES-1 returns it to 0.
- R8: `chk_align_fault` is high exactly when `chk_ifetch` is high and address bits [1:0] are not 00.
- R9: `chk_uncached` is high exactly when address bits 31 and 29 are both set (all bits of 0xA0000000).
- R10: Each cycle with `lk_req` high adds one, at the next edge, to the read-hit, read-miss, write-hit or write-miss counter, chosen by `lk_is_write` and `lk_hit`. `st_hits` and `st_misses` are the read-plus-write sums.
- R11: After reset every slot is empty, the pointer is 0 and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request strobe for the counters |
| lk_is_write | input | 1 | Request is a data write |
| lk_vpn | input | VPN_W | Request virtual page number |
| lk_asid | input | ASID_W | Request address-space tag |
| lk_hit | output | 1 | Translation hit |
| lk_idx | output | IDX_W+1 | Matching slot, all ones if none |
| lk_pfn | output | PFN_W | Selected frame number |
| wr_en | input | 1 | Indexed write strobe |
| wr_idx | input | IDX_W+1 | Target slot |
| wr_vpn | input | VPN_W | Page number to store |
| wr_mask | input | VPN_W | Page mask to store |
| wr_asid | input | ASID_W | Address-space tag to store |
| wr_global | input | 1 | Global flag to store |
| wr_v0 | input | 1 | Even valid bit |
| wr_v1 | input | 1 | Odd valid bit |
| wr_pfn0 | input | PFN_W | Even frame |
| wr_pfn1 | input | PFN_W | Odd frame |
| wr_oor | output | 1 | Write index out of range |
| flush | input | 1 | Clear all slots and pointer |
| nxt_adv | input | 1 | Advance next-slot pointer |
| nxt_ptr | output | IDX_W | Next-slot pointer |
| nxt_vpn | output | VPN_W | Pointed slot page number |
| nxt_mask | output | VPN_W | Pointed slot mask |
| nxt_asid | output | ASID_W | Pointed slot tag |
| nxt_global | output | 1 | Pointed slot global flag |
| nxt_v0 | output | 1 | Pointed slot even valid |
| nxt_v1 | output | 1 | Pointed slot odd valid |
| nxt_pfn0 | output | PFN_W | Pointed slot even frame |
| nxt_pfn1 | output | PFN_W | Pointed slot odd frame |
| chk_addr | input | 32 | Address to classify |
| chk_ifetch | input | 1 | Address is an instruction fetch |
| chk_align_fault | output | 1 | Misaligned fetch |
| chk_uncached | output | 1 | Address in uncacheable window |
| st_rd_hits | output | CNT_W | Read hits |
| st_rd_misses | output | CNT_W | Read misses |
| st_wr_hits | output | CNT_W | Write hits |
| st_wr_misses | output | CNT_W | Write misses |
| st_hits | output | CNT_W+1 | Total hits |
| st_misses | output | CNT_W+1 | Total misses |

## Verification
A flush can arrive in the same cycle as a slot write and a pointer advance. All three act on the same storage and the same pointer register. The bench drives all three on one cycle, with a write that would otherwise make a valid slot. It then judges the result at the ports: the pointer must read 0 with the pointed slot empty, and a full lookup sweep must miss everywhere with an all-ones index.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;
  localparam int ADDR_W = 32;
  localparam logic [ADDR_W-1:0] UNCACHE_PAT = 32'hA000_0000;

  // Instruction fetches must be 4-byte aligned.
  function automatic logic fetch_misaligned(input logic [ADDR_W-1:0] a,
                                            input logic is_fetch);
    return is_fetch && (a[1:0] != 2'b00);
  endfunction

  // Address lies in the uncacheable window when it covers every pattern bit.
  function automatic logic in_uncached_window(input logic [ADDR_W-1:0] a);
    return (a & UNCACHE_PAT) == UNCACHE_PAT;
  endfunction
endpackage

// File: rtl/swtlb_store.sv
module swtlb_store #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 10,
  parameter int ASID_W  = 4,
  parameter int PFN_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PIDX_W = IDX_W + 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               flush,
  input  logic                               wr_en,
  input  logic [PIDX_W-1:0]                  wr_idx,
  input  logic [VPN_W-1:0]                   wr_vpn,
  input  logic [VPN_W-1:0]                   wr_mask,
  input  logic [ASID_W-1:0]                  wr_asid,
  input  logic                               wr_global,
  input  logic                               wr_v0,
  input  logic                               wr_v1,
  input  logic [PFN_W-1:0]                   wr_pfn0,
  input  logic [PFN_W-1:0]                   wr_pfn1,
  input  logic                               nxt_adv,
  output logic                               wr_oor,
  output logic [IDX_W-1:0]                   ptr,
  output logic [ENTRIES-1:0][VPN_W-1:0]      e_vpn,
  output logic [ENTRIES-1:0][VPN_W-1:0]      e_mask,
  output logic [ENTRIES-1:0][ASID_W-1:0]     e_asid,
  output logic [ENTRIES-1:0]                 e_glob,
  output logic [ENTRIES-1:0]                 e_v0,
  output logic [ENTRIES-1:0]                 e_v1,
  output logic [ENTRIES-1:0][PFN_W-1:0]      e_pfn0,
  output logic [ENTRIES-1:0][PFN_W-1:0]      e_pfn1
);
  localparam logic [IDX_W-1:0]  LAST  = IDX_W'(ENTRIES - 1);
  localparam logic [PIDX_W-1:0] LIMIT = PIDX_W'(ENTRIES);

  logic wr_take;
  assign wr_oor  = wr_en && (wr_idx >= LIMIT);
  assign wr_take = wr_en && !wr_oor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vpn <= '0; e_mask <= '0; e_asid <= '0; e_glob <= '0;
      e_v0 <= '0; e_v1 <= '0; e_pfn0 <= '0; e_pfn1 <= '0;
      ptr <= '0;
    end else if (flush) begin
      e_vpn <= '0; e_mask <= '0; e_asid <= '0; e_glob <= '0;
      e_v0 <= '0; e_v1 <= '0; e_pfn0 <= '0; e_pfn1 <= '0;
      ptr <= '0;
    end else begin
      if (wr_take) begin
        e_vpn[wr_idx[IDX_W-1:0]]  <= wr_vpn;
        e_mask[wr_idx[IDX_W-1:0]] <= wr_mask;
        e_asid[wr_idx[IDX_W-1:0]] <= wr_asid;
        e_glob[wr_idx[IDX_W-1:0]] <= wr_global;
        e_v0[wr_idx[IDX_W-1:0]]   <= wr_v0;
        e_v1[wr_idx[IDX_W-1:0]]   <= wr_v1;
        e_pfn0[wr_idx[IDX_W-1:0]] <= wr_pfn0;
        e_pfn1[wr_idx[IDX_W-1:0]] <= wr_pfn1;
      end
      if (nxt_adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (e_v0 == '0 && e_v1 == '0 && ptr == '0)); // R6
  AST_OOR_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_oor && !flush) |=> (e_vpn == $past(e_vpn) && e_pfn0 == $past(e_pfn0)
                            && e_pfn1 == $past(e_pfn1) && e_v0 == $past(e_v0))); // R5
  AST_PTR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_adv && !flush && ptr == LAST) |=> (ptr == '0)); // R7
  AST_PTR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_adv && !flush && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1)); // R7
endmodule

// File: rtl/swtlb_match.sv
module swtlb_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 10,
  parameter int ASID_W  = 4,
  parameter int PFN_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PIDX_W = IDX_W + 1
) (
  input  logic [VPN_W-1:0]                   lk_vpn,
  input  logic [ASID_W-1:0]                  lk_asid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]      e_vpn,
  input  logic [ENTRIES-1:0][VPN_W-1:0]      e_mask,
  input  logic [ENTRIES-1:0][ASID_W-1:0]     e_asid,
  input  logic [ENTRIES-1:0]                 e_glob,
  input  logic [ENTRIES-1:0]                 e_v0,
  input  logic [ENTRIES-1:0]                 e_v1,
  input  logic [ENTRIES-1:0][PFN_W-1:0]      e_pfn0,
  input  logic [ENTRIES-1:0][PFN_W-1:0]      e_pfn1,
  output logic                               found,
  output logic                               hit,
  output logic [PIDX_W-1:0]                  idx,
  output logic [PFN_W-1:0]                   pfn
);
  // Bits ignored by the compare: the mask plus the pair-select bit above it.
  function automatic logic [VPN_W-1:0] pair_span(input logic [VPN_W-1:0] m);
    return m | {m[VPN_W-2:0], 1'b1};
  endfunction

  // Pair-select bit: the request bit just above the mask.
  function automatic logic pair_select(input logic [VPN_W-1:0] v,
                                       input logic [VPN_W-1:0] m);
    return |(v & pair_span(m) & ~m);
  endfunction

  logic [ENTRIES-1:0] cand;
  logic [IDX_W-1:0]   win;
  logic               sel;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [VPN_W-1:0] span;
    assign span    = pair_span(e_mask[i]);
    assign cand[i] = (e_v0[i] | e_v1[i])
                   && (((lk_vpn ^ e_vpn[i]) & ~span) == '0)
                   && (e_glob[i] || (e_asid[i] == lk_asid));
  end

  always_comb begin
    win = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (cand[i]) win = IDX_W'(i);
  end

  assign found = |cand;
  assign sel   = pair_select(lk_vpn, e_mask[win]);
  assign idx   = found ? {1'b0, win} : '1;
  assign hit   = found && (sel ? e_v1[win] : e_v0[win]);
  assign pfn   = !found ? '0 : (sel ? e_pfn1[win] : e_pfn0[win]);
endmodule

// File: rtl/swtlb_stats.sv
module swtlb_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             is_wr,
  input  logic             hit,
  output logic [CNT_W-1:0] rd_hits,
  output logic [CNT_W-1:0] rd_misses,
  output logic [CNT_W-1:0] wr_hits,
  output logic [CNT_W-1:0] wr_misses,
  output logic [CNT_W:0]   tot_hits,
  output logic [CNT_W:0]   tot_misses
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hits <= '0; rd_misses <= '0; wr_hits <= '0; wr_misses <= '0;
    end else if (req) begin
      case ({is_wr, hit})
        2'b01:   rd_hits   <= rd_hits + 1'b1;
        2'b00:   rd_misses <= rd_misses + 1'b1;
        2'b11:   wr_hits   <= wr_hits + 1'b1;
        default: wr_misses <= wr_misses + 1'b1;
      endcase
    end
  end

  assign tot_hits   = {1'b0, rd_hits} + {1'b0, wr_hits};
  assign tot_misses = {1'b0, rd_misses} + {1'b0, wr_misses};

  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(rd_hits) && $stable(rd_misses)
              && $stable(wr_hits) && $stable(wr_misses))); // R10
  AST_READ_HIT_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !is_wr && hit) |=> (rd_hits != $past(rd_hits) && $stable(wr_hits))); // R10
endmodule

// File: rtl/swtlb_top.sv
module swtlb_top #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 10,
  parameter int ASID_W  = 4,
  parameter int PFN_W   = 12,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PIDX_W = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_req,
  input  logic                 lk_is_write,
  input  logic [VPN_W-1:0]     lk_vpn,
  input  logic [ASID_W-1:0]    lk_asid,
  output logic                 lk_hit,
  output logic [PIDX_W-1:0]    lk_idx,
  output logic [PFN_W-1:0]     lk_pfn,
  input  logic                 wr_en,
  input  logic [PIDX_W-1:0]    wr_idx,
  input  logic [VPN_W-1:0]     wr_vpn,
  input  logic [VPN_W-1:0]     wr_mask,
  input  logic [ASID_W-1:0]    wr_asid,
  input  logic                 wr_global,
  input  logic                 wr_v0,
  input  logic                 wr_v1,
  input  logic [PFN_W-1:0]     wr_pfn0,
  input  logic [PFN_W-1:0]     wr_pfn1,
  output logic                 wr_oor,
  input  logic                 flush,
  input  logic                 nxt_adv,
  output logic [IDX_W-1:0]     nxt_ptr,
  output logic [VPN_W-1:0]     nxt_vpn,
  output logic [VPN_W-1:0]     nxt_mask,
  output logic [ASID_W-1:0]    nxt_asid,
  output logic                 nxt_global,
  output logic                 nxt_v0,
  output logic                 nxt_v1,
  output logic [PFN_W-1:0]     nxt_pfn0,
  output logic [PFN_W-1:0]     nxt_pfn1,
  input  logic [31:0]          chk_addr,
  input  logic                 chk_ifetch,
  output logic                 chk_align_fault,
  output logic                 chk_uncached,
  output logic [CNT_W-1:0]     st_rd_hits,
  output logic [CNT_W-1:0]     st_rd_misses,
  output logic [CNT_W-1:0]     st_wr_hits,
  output logic [CNT_W-1:0]     st_wr_misses,
  output logic [CNT_W:0]       st_hits,
  output logic [CNT_W:0]       st_misses
);
  logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn, e_mask;
  logic [ENTRIES-1:0][ASID_W-1:0] e_asid;
  logic [ENTRIES-1:0]             e_glob, e_v0, e_v1;
  logic [ENTRIES-1:0][PFN_W-1:0]  e_pfn0, e_pfn1;
  logic                           lk_found;

  swtlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) store_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_mask(wr_mask), .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_v0(wr_v0), .wr_v1(wr_v1), .wr_pfn0(wr_pfn0), .wr_pfn1(wr_pfn1),
    .nxt_adv(nxt_adv), .wr_oor(wr_oor), .ptr(nxt_ptr),
    .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_glob(e_glob),
    .e_v0(e_v0), .e_v1(e_v1), .e_pfn0(e_pfn0), .e_pfn1(e_pfn1));

  swtlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) match_i (
    .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_glob(e_glob),
    .e_v0(e_v0), .e_v1(e_v1), .e_pfn0(e_pfn0), .e_pfn1(e_pfn1),
    .found(lk_found), .hit(lk_hit), .idx(lk_idx), .pfn(lk_pfn));

  swtlb_stats #(.CNT_W(CNT_W)) stats_i (
    .clk(clk), .rst_n(rst_n), .req(lk_req), .is_wr(lk_is_write), .hit(lk_hit),
    .rd_hits(st_rd_hits), .rd_misses(st_rd_misses), .wr_hits(st_wr_hits),
    .wr_misses(st_wr_misses), .tot_hits(st_hits), .tot_misses(st_misses));

  assign nxt_vpn    = e_vpn[nxt_ptr];
  assign nxt_mask   = e_mask[nxt_ptr];
  assign nxt_asid   = e_asid[nxt_ptr];
  assign nxt_global = e_glob[nxt_ptr];
  assign nxt_v0     = e_v0[nxt_ptr];
  assign nxt_v1     = e_v1[nxt_ptr];
  assign nxt_pfn0   = e_pfn0[nxt_ptr];
  assign nxt_pfn1   = e_pfn1[nxt_ptr];

  assign chk_align_fault = swtlb_pkg::fetch_misaligned(chk_addr, chk_ifetch);
  assign chk_uncached    = swtlb_pkg::in_uncached_window(chk_addr);

  AST_HIT_HAS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_found && !(&lk_idx))); // R3
  AST_DATA_NEVER_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_ifetch |-> !chk_align_fault); // R8
endmodule

// File: tb/swtlb_top_tb_top.sv
module swtlb_top_tb_top;
  localparam int N = 4, VW = 8, AW = 3, PW = 8, CW = 16;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic lk_req = 0, lk_is_write = 0;
  logic [VW-1:0] lk_vpn = 0; logic [AW-1:0] lk_asid = 0;
  logic lk_hit; logic [2:0] lk_idx; logic [PW-1:0] lk_pfn;
  logic wr_en = 0; logic [2:0] wr_idx = 0;
  logic [VW-1:0] wr_vpn = 0, wr_mask = 0; logic [AW-1:0] wr_asid = 0;
  logic wr_global = 0, wr_v0 = 0, wr_v1 = 0; logic [PW-1:0] wr_pfn0 = 0, wr_pfn1 = 0;
  logic wr_oor, flush = 0, nxt_adv = 0;
  logic [1:0] nxt_ptr; logic [VW-1:0] nxt_vpn, nxt_mask; logic [AW-1:0] nxt_asid;
  logic nxt_global, nxt_v0, nxt_v1; logic [PW-1:0] nxt_pfn0, nxt_pfn1;
  logic [31:0] chk_addr = 0; logic chk_ifetch = 0, chk_align_fault, chk_uncached;
  logic [CW-1:0] st_rd_hits, st_rd_misses, st_wr_hits, st_wr_misses;
  logic [CW:0] st_hits, st_misses;

  swtlb_top #(.ENTRIES(N), .VPN_W(VW), .ASID_W(AW), .PFN_W(PW), .CNT_W(CW)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  logic [VW-1:0] m_vpn[N], m_mask[N]; logic [AW-1:0] m_asid[N];
  logic m_g[N], m_v0[N], m_v1[N]; logic [PW-1:0] m_p0[N], m_p1[N];
  int e_rh = 0, e_rm = 0, e_wh = 0, e_wm = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = 0; m_mask[i] = 0; m_asid[i] = 0; m_g[i] = 0;
      m_v0[i] = 0; m_v1[i] = 0; m_p0[i] = 0; m_p1[i] = 0;
    end
  endtask

  // Indexed write (R4, R5); wr_oor checked in the write cycle.
  task automatic put(input int idx, input int vpn, input int mask, input int asid,
                     input bit g, input bit v0, input bit v1, input int p0, input int p1);
    @(negedge clk);
    wr_en = 1; wr_idx = 3'(idx); wr_vpn = VW'(vpn); wr_mask = VW'(mask);
    wr_asid = AW'(asid); wr_global = g; wr_v0 = v0; wr_v1 = v1;
    wr_pfn0 = PW'(p0); wr_pfn1 = PW'(p1);
    #1 check(idx >= N ? "R5 oor flag" : "R4 oor flag", 32'(wr_oor), 32'(idx >= N));
    @(negedge clk); wr_en = 0;
    if (idx < N) begin
      m_vpn[idx] = VW'(vpn); m_mask[idx] = VW'(mask); m_asid[idx] = AW'(asid);
      m_g[idx] = g; m_v0[idx] = v0; m_v1[idx] = v1; m_p0[idx] = PW'(p0); m_p1[idx] = PW'(p1);
    end
  endtask

  // Reference match: loops over bits rather than masking (R1, R2, R3).
  task automatic expect_lookup(input int vpn, input int asid, output bit found,
                               output int idx, output bit hit, output int pfn);
    found = 0; idx = 7; hit = 0; pfn = 0;
    for (int i = N - 1; i >= 0; i--) begin
      int k; bit ok; bit s;
      k = 0;
      for (int b = 0; b < VW; b++) if (m_mask[i][b]) k++;
      ok = (m_v0[i] || m_v1[i]) && (m_g[i] || m_asid[i] == AW'(asid));
      for (int b = k + 1; b < VW; b++) if (((vpn >> b) & 1) != int'(m_vpn[i][b])) ok = 0;
      s = (k < VW) ? bit'((vpn >> k) & 1) : 1'b0;
      if (ok) begin
        found = 1; idx = i; hit = s ? m_v1[i] : m_v0[i]; pfn = s ? m_p1[i] : m_p0[i];
      end
    end
  endtask

  task automatic sweep(input string tag);
    for (int v = 0; v < (1 << VW); v++)
      for (int a = 0; a < (1 << AW); a++) begin
        bit f, h, w; int ei, ep;
        @(negedge clk);
        w = bit'((v ^ a) & 1);
        lk_req = 1; lk_is_write = w; lk_vpn = VW'(v); lk_asid = AW'(a);
        expect_lookup(v, a, f, ei, h, ep);
        #1;
        check({tag, " R1 R2 hit"}, 32'(lk_hit), 32'(h));
        check({tag, " R3 index"}, 32'(lk_idx), 32'(ei));
        if (h) check({tag, " R2 frame"}, 32'(lk_pfn), 32'(ep));
        if (w) begin if (h) e_wh++; else e_wm++; end
        else   begin if (h) e_rh++; else e_rm++; end
      end
    @(negedge clk); lk_req = 0;
    check({tag, " R10 rd hits"}, 32'(st_rd_hits), 32'(e_rh));
    check({tag, " R10 rd misses"}, 32'(st_rd_misses), 32'(e_rm));
    check({tag, " R10 wr hits"}, 32'(st_wr_hits), 32'(e_wh));
    check({tag, " R10 wr misses"}, 32'(st_wr_misses), 32'(e_wm));
    check({tag, " R10 total hits"}, 32'(st_hits), 32'(e_rh + e_wh));
    check({tag, " R10 total misses"}, 32'(st_misses), 32'(e_rm + e_wm));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int pe;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check("R11 pointer", 32'(nxt_ptr), 0);
    check("R11 slot empty", 32'({nxt_v0, nxt_v1}), 0);
    check("R11 counters", 32'(st_hits + st_misses), 0);
    check("R11 lookup miss", 32'(lk_idx), 7);

    // Overlapping slots: slot1 (global, 8 pages) and slot3 cover 0x44..0x47.
    put(0, 'h10, 'h00, 1, 0, 1, 0, 'hA0, 'hA1);
    put(1, 'h40, 'h03, 2, 1, 1, 1, 'hB0, 'hB1);
    put(2, 'h10, 'h00, 2, 0, 1, 1, 'hC0, 'hC1);
    put(3, 'h44, 'h01, 1, 0, 1, 1, 'hD0, 'hD1);
    sweep("load");

    // R7 pointer walk with wrap
    pe = 0;
    for (int s = 0; s < N + 2; s++) begin
      @(negedge clk);
      check("R7 pointer", 32'(nxt_ptr), 32'(pe));
      check("R7 slot page", 32'(nxt_vpn), 32'(m_vpn[pe]));
      check("R7 slot odd frame", 32'(nxt_pfn1), 32'(m_p1[pe]));
      check("R7 slot mask", 32'(nxt_mask), 32'(m_mask[pe]));
      nxt_adv = 1;
      @(negedge clk); nxt_adv = 0;
      pe = (pe + 1) % N;
    end

    // R5 out-of-range writes leave the table intact
    put(4, 'hFF, 0, 0, 1, 1, 1, 'h11, 'h22);
    put(7, 'h10, 0, 1, 1, 1, 1, 'h33, 'h44);
    sweep("oor");

    // R4 overwrite of valid slots, including making one fully invalid
    put(0, 'h10, 'h00, 1, 0, 0, 0, 'hE0, 'hE1);
    put(2, 'h20, 'h07, 3, 0, 0, 1, 'hF0, 'hF1);
    sweep("overwrite");

    // R6 flush colliding with a write and an advance in the same cycle
    @(negedge clk);
    flush = 1; nxt_adv = 1; wr_en = 1; wr_idx = 3'd1; wr_vpn = 8'h55;
    wr_mask = 0; wr_asid = 0; wr_global = 1; wr_v0 = 1; wr_v1 = 1;
    @(negedge clk); flush = 0; nxt_adv = 0; wr_en = 0;
    model_clear();
    check("R6 pointer reset", 32'(nxt_ptr), 0);
    check("R6 slot cleared", 32'({nxt_v0, nxt_v1, nxt_global}), 0);
    sweep("flush");

    // R8 alignment and R9 uncacheable window
    for (int n = 0; n < 16; n++)
      for (int lo = 0; lo < 4; lo++)
        for (int f = 0; f < 2; f++) begin
          @(negedge clk);
          chk_addr = (32'(n) << 28) | (32'(lo)) | (32'(n * 'h0123457) << 2);
          chk_ifetch = f[0];
          #1;
          check("R8 align fault", 32'(chk_align_fault), 32'(f == 1 && lo != 0));
          check("R9 uncached", 32'(chk_uncached), 32'(((n >> 3) & 1) & ((n >> 1) & 1)));
        end
    finish_run();
  end
endmodule